// File: doc/BRIEF.md
# Event Timestamp Capture Log

This block sits beside the timekeeping counters of a real-time clock. It keeps a short record of when notable events happened. A trigger can come from an external event input or from internal status changes. When it fires, the block copies the current time value into a log entry, together with a snapshot of four status flags: oscillator stopped, backup supply below its low threshold, main supply below its detect threshold, and main supply below the backup supply. Each of the four internal sources has its own enable. A single select bit chooses whether the external input or the internal sources drive capture.

The log holds up to eight entries. In multi-record mode, successive events fill consecutive entries until the log is full, and later events are dropped. In single-record mode, every event overwrites entry 0. Software sees the next-write pointer and full and empty flags in a status register. It can clear the log, and it should turn capture off before reading entries back, so that no event changes them during the read. Entries are read through a plain index port.

Top module: `evt_stamp_log`

## Requirements
- R1: After reset, the status register reads pointer 0, empty 1 and full 0. The control and enable registers read 0.
- R2: With capture on and the external source selected, a rising edge on `ext_evt` stores `now_time` and `stat_flags` into the entry at the pointer at that clock edge. The stored values are readable on the `rec_*` port after the edge.
- R3: An external input held high produces exactly one capture. A flag held high produces exactly one capture.
- R4: With the internal sources selected, a rising edge on `stat_flags[i]` captures only when enable bit i is set.
- R5: With the external source selected, flag edges never capture. With the internal sources selected, `ext_evt` edges never capture.
- R6: While the capture-enable bit is 0, no event changes the pointer, the flags or any entry.
- R7: In multi-record mode, each capture advances the pointer by one. The eighth capture sets full and wraps the pointer to 0. While full, events are ignored and entries are unchanged. Empty and full are never both 1.
- R8: In single-record mode, each capture overwrites entry 0, clears empty and leaves the pointer and full unchanged.
- R9: Writing 1 to the clear bit makes that bit read 1 for one cycle. At the next edge the pointer goes to 0, empty to 1 and full to 0, and the bit returns to 0. A capture in that same cycle is discarded.
- R10: The flag bit layout is the same in `stat_flags`, `rec_flags` and the enable register: bit 0 is oscillator stop, bit 1 is backup low, bit 2 is main-supply detect, and bit 3 is main below backup.
- R11: The register map is as follows. Address 0 is control: bit 0 is multi-record, bit 1 is clear, bit 2 is source select (1 = internal), and bit 3 is capture enable. Address 1 holds the source enables in bits 3:0. Address 2 is status: pointer in bits 2:0, empty in bit 3 and full in bit 4. Address 2 is read-only. `reg_rdata` reflects `reg_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| now_time | input | TIME_W | Current time value from the counters |
| ext_evt | input | 1 | External event input, already debounced |
| stat_flags | input | 4 | Live status flags (layout per R10) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| rec_sel | input | PTR_W | Index of the log entry to read |
| rec_time | output | TIME_W | Time stored in the selected entry |
| rec_flags | output | 4 | Flags stored in the selected entry |

## Verification
The bench builds the log with its default eight entries and a 16-bit time value. This makes it practical to fill every entry, run past full, and check that the pointer wraps. Single-record mode is swept over all sixteen flag snapshots. Each internal source is tried both enabled and disabled, with the other sources set the opposite way, so that a wrong source-to-enable mapping shows up. A clear is also issued in the same cycle as a capture, to check that the clear takes precedence.

// File: rtl/evt_stamp_pkg.sv
package evt_stamp_pkg;
  localparam int NFLAG  = 4;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;

  // flag positions shared by stat_flags, records and source enables
  localparam int FL_OSC  = 0;
  localparam int FL_LOW  = 1;
  localparam int FL_DET  = 2;
  localparam int FL_CMP  = 3;

  // control register bit positions
  localparam int CB_MULTI = 0;
  localparam int CB_CLR   = 1;
  localparam int CB_SEL   = 2;
  localparam int CB_CAPEN = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL   = 2'd0,
    RA_SRCEN  = 2'd1,
    RA_STATUS = 2'd2
  } reg_addr_e;

  typedef logic [NFLAG-1:0] flags_t;

  typedef struct packed {
    logic cap_en;
    logic src_int;
    logic clr;
    logic multi;
  } ctrl_t;
endpackage

// File: rtl/evt_trig_detect.sv
module evt_trig_detect
  import evt_stamp_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   ext_evt,
  input  flags_t src_flags,
  input  flags_t src_en,
  input  logic   src_int,
  input  logic   cap_en,
  output logic   fire
);
  logic   ext_q;
  flags_t flags_q;
  flags_t int_rise;
  logic   ext_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q   <= 1'b0;
      flags_q <= '0;
    end else begin
      ext_q   <= ext_evt;
      flags_q <= src_flags;
    end
  end

  for (genvar g = 0; g < NFLAG; g++) begin : g_src
    assign int_rise[g] = src_en[g] & src_flags[g] & ~flags_q[g];
  end

  assign ext_rise = ext_evt & ~ext_q;
  assign fire     = cap_en & (src_int ? |int_rise : ext_rise);
endmodule

// File: rtl/evt_log_store.sv
module evt_log_store
  import evt_stamp_pkg::*;
#(
  parameter int TIME_W = 32,
  parameter int DEPTH  = 8,
  parameter int PTR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              clr,
  input  logic              multi_en,
  input  logic [TIME_W-1:0] cap_time,
  input  flags_t            cap_flags,
  input  logic [PTR_W-1:0]  rec_sel,
  output logic [PTR_W-1:0]  ptr,
  output logic              empty,
  output logic              full,
  output logic [TIME_W-1:0] rec_time,
  output flags_t            rec_flags
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [TIME_W-1:0] time_q [DEPTH];
  flags_t            flag_q [DEPTH];
  logic              wr_go;
  logic [PTR_W-1:0]  wr_idx;

  assign wr_go  = fire & ~clr & (multi_en ? ~full : 1'b1);
  assign wr_idx = multi_en ? ptr : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        time_q[i] <= '0;
        flag_q[i] <= '0;
      end
    end else if (wr_go) begin
      time_q[wr_idx] <= cap_time;
      flag_q[wr_idx] <= cap_flags;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr   <= '0;
      empty <= 1'b1;
      full  <= 1'b0;
    end else if (clr) begin
      ptr   <= '0;
      empty <= 1'b1;
      full  <= 1'b0;
    end else if (wr_go) begin
      empty <= 1'b0;
      if (multi_en) begin
        ptr <= ptr + 1'b1;
        if (ptr == LAST) full <= 1'b1;
      end
    end
  end

  assign rec_time  = time_q[rec_sel];
  assign rec_flags = flag_q[rec_sel];
endmodule

// File: rtl/evt_ctrl_regs.sv
module evt_ctrl_regs
  import evt_stamp_pkg::*;
#(
  parameter int PTR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [PTR_W-1:0]  st_ptr,
  input  logic              st_empty,
  input  logic              st_full,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              multi_en,
  output logic              src_int,
  output logic              cap_en,
  output logic              clr_pulse,
  output flags_t            src_en
);
  ctrl_t ctrl_q;
  logic  wr_ctrl;
  logic  wr_src;

  assign wr_ctrl = reg_wr && (reg_addr == RA_CTRL);
  assign wr_src  = reg_wr && (reg_addr == RA_SRCEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      src_en <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.multi   <= reg_wdata[CB_MULTI];
        ctrl_q.clr     <= reg_wdata[CB_CLR];
        ctrl_q.src_int <= reg_wdata[CB_SEL];
        ctrl_q.cap_en  <= reg_wdata[CB_CAPEN];
      end else begin
        ctrl_q.clr <= 1'b0;
      end
      if (wr_src) src_en <= reg_wdata[NFLAG-1:0];
    end
  end

  assign multi_en  = ctrl_q.multi;
  assign src_int   = ctrl_q.src_int;
  assign cap_en    = ctrl_q.cap_en;
  assign clr_pulse = ctrl_q.clr;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CTRL:   reg_rdata = DATA_W'(ctrl_q);
      RA_SRCEN:  reg_rdata = DATA_W'(src_en);
      RA_STATUS: reg_rdata = DATA_W'({st_full, st_empty, st_ptr});
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/evt_stamp_log.sv
module evt_stamp_log
  import evt_stamp_pkg::*;
#(
  parameter int TIME_W = 32,
  parameter int DEPTH  = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] now_time,
  input  logic              ext_evt,
  input  logic [3:0]        stat_flags,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic [PTR_W-1:0]  rec_sel,
  output logic [TIME_W-1:0] rec_time,
  output logic [3:0]        rec_flags
);
  logic             multi_en, src_int, cap_en, clr_pulse, cap_fire;
  flags_t           src_en;
  logic [PTR_W-1:0] wptr;
  logic             log_empty, log_full;

  evt_ctrl_regs #(.PTR_W(PTR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .st_ptr    (wptr),
    .st_empty  (log_empty),
    .st_full   (log_full),
    .reg_rdata (reg_rdata),
    .multi_en  (multi_en),
    .src_int   (src_int),
    .cap_en    (cap_en),
    .clr_pulse (clr_pulse),
    .src_en    (src_en)
  );

  evt_trig_detect u_trig (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_evt   (ext_evt),
    .src_flags (stat_flags),
    .src_en    (src_en),
    .src_int   (src_int),
    .cap_en    (cap_en),
    .fire      (cap_fire)
  );

  evt_log_store #(.TIME_W(TIME_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (cap_fire),
    .clr       (clr_pulse),
    .multi_en  (multi_en),
    .cap_time  (now_time),
    .cap_flags (stat_flags),
    .rec_sel   (rec_sel),
    .ptr       (wptr),
    .empty     (log_empty),
    .full      (log_full),
    .rec_time  (rec_time),
    .rec_flags (rec_flags)
  );
endmodule

// File: rtl/evt_stamp_log_chk.sv
module evt_stamp_log_chk #(
  parameter int PTR_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fire,
  input logic             clr_pulse,
  input logic             multi_en,
  input logic             cap_en,
  input logic [PTR_W-1:0] ptr,
  input logic             empty,
  input logic             full
);
  p_excl_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full));

  p_clear_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |=> (ptr == '0) && empty && !full);

  p_ptr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fire && multi_en && !full && !clr_pulse |=> (ptr == PTR_W'($past(ptr) + 1'b1)) && !empty);

  p_full_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    full && !clr_pulse |=> full && $stable(ptr));

  p_single_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !multi_en && !clr_pulse |=> $stable(ptr) && $stable(full) && !empty);

  p_idle_when_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en && !clr_pulse |=> $stable(ptr) && $stable(empty) && $stable(full));
endmodule

bind evt_stamp_log evt_stamp_log_chk #(.PTR_W(PTR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fire      (cap_fire),
  .clr_pulse (clr_pulse),
  .multi_en  (multi_en),
  .cap_en    (cap_en),
  .ptr       (wptr),
  .empty     (log_empty),
  .full      (log_full)
);

// File: tb/test_evt_stamp_log.sv
module test_evt_stamp_log;
  localparam int TW = 16;
  localparam int DEPTH = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [TW-1:0] now_time = '0;
  logic          ext_evt = 1'b0;
  logic [3:0]    stat_flags = '0;
  logic          reg_wr = 1'b0;
  logic [1:0]    reg_addr = '0;
  logic [7:0]    reg_wdata = '0;
  logic [7:0]    reg_rdata;
  logic [2:0]    rec_sel = '0;
  logic [TW-1:0] rec_time;
  logic [3:0]    rec_flags;

  int nchk = 0;
  int nfail = 0;

  evt_stamp_log #(.TIME_W(TW), .DEPTH(DEPTH)) i_evt_stamp_log (
    .clk(clk), .rst_n(rst_n), .now_time(now_time), .ext_evt(ext_evt),
    .stat_flags(stat_flags), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rec_sel(rec_sel),
    .rec_time(rec_time), .rec_flags(rec_flags)
  );

  always #5 clk = ~clk;

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wreg(logic [1:0] a, logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    cyc();
    reg_wr = 1'b0;
  endtask

  function automatic int rd(logic [1:0] a);
    reg_addr = a;
    return int'(reg_rdata);
  endfunction

  task automatic rreg(logic [1:0] a, output int v);
    reg_addr = a;
    #1;
    v = int'(reg_rdata);
  endtask

  task automatic ext_pulse();
    ext_evt = 1'b1; cyc();
    ext_evt = 1'b0; cyc();
  endtask

  function automatic int stat(int p, int e, int f);
    return (f << 4) | (e << 3) | p;
  endfunction

  task automatic chk_stat(string req, int p, int e, int f);
    int v;
    rreg(2'd2, v);
    chk(req, v, stat(p, e, f));
  endtask

  task automatic chk_rec(string req, int idx, int t, int fl);
    rec_sel = 3'(idx);
    #1;
    chk(req, int'(rec_time), t);
    chk(req, int'(rec_flags), fl);
  endtask

  task automatic do_clear(logic [7:0] keep);
    wreg(2'd0, keep | 8'h02);
    cyc();
  endtask

  initial begin
    #1000000;
    nfail++;
    nchk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc();

    // R1 reset state
    chk_stat("R1", 0, 1, 0);
    rreg(2'd0, v); chk("R1", v, 0);
    rreg(2'd1, v); chk("R1", v, 0);

    // R6 capture disabled
    now_time = 16'h1234; stat_flags = 4'h5;
    ext_pulse();
    chk_stat("R6", 0, 1, 0);
    chk_rec("R6", 0, 0, 0);
    stat_flags = 4'h0;

    // R11 control readback: cap_en | multi
    wreg(2'd0, 8'h09);
    rreg(2'd0, v); chk("R11", v, 9);
    wreg(2'd2, 8'hFF);
    chk_stat("R11", 0, 1, 0);

    // R2 R7 fill all entries
    for (int i = 0; i < DEPTH; i++) begin
      now_time = 16'(1000 + i * 37);
      stat_flags = 4'((i * 5) & 15);
      ext_pulse();
      chk_stat("R7", (i + 1) % DEPTH, 0, (i == DEPTH - 1) ? 1 : 0);
    end
    for (int i = 0; i < DEPTH; i++) chk_rec("R2", i, 1000 + i * 37, (i * 5) & 15);

    // R7 extra event ignored when full
    now_time = 16'h9999; stat_flags = 4'hF;
    ext_pulse();
    chk_stat("R7", 0, 0, 1);
    chk_rec("R7", 0, 1000, 0);

    // R9 clear
    wreg(2'd0, 8'h0B);
    rreg(2'd0, v); chk("R9", (v >> 1) & 1, 1);
    cyc();
    chk_stat("R9", 0, 1, 0);
    rreg(2'd0, v); chk("R9", v, 9);

    // R3 held external level -> one capture
    ext_evt = 1'b1;
    repeat (5) cyc();
    ext_evt = 1'b0; cyc();
    chk_stat("R3", 1, 0, 0);

    // R5 flag edges ignored with external select
    do_clear(8'h09);
    wreg(2'd1, 8'h0F);
    stat_flags = 4'hF; cyc(); cyc();
    stat_flags = 4'h0; cyc();
    chk_stat("R5", 0, 1, 0);

    // R4 R10 internal sources, each enabled or disabled
    wreg(2'd0, 8'h0D);
    begin
      int cnt = 0;
      for (int s = 0; s < 4; s++) begin
        for (int en = 0; en < 2; en++) begin
          logic [3:0] m;
          m = 4'(1 << s);
          wreg(2'd1, en ? {4'h0, m} : {4'h0, ~m});
          now_time = 16'(200 + s * 10 + en);
          stat_flags = m; cyc();
          if (en) cnt++;
          chk_stat("R4", cnt, (cnt == 0) ? 1 : 0, 0);
          repeat (3) cyc();
          chk_stat("R3", cnt, (cnt == 0) ? 1 : 0, 0);
          if (en) chk_rec("R10", cnt - 1, 200 + s * 10 + 1, int'(m));
          stat_flags = 4'h0; cyc();
        end
      end
      // R5 external ignored with internal select
      ext_pulse();
      chk_stat("R5", cnt, 0, 0);
    end

    // R8 single mode, all flag snapshots
    wreg(2'd0, 8'h08);
    do_clear(8'h08);
    for (int f = 0; f < 16; f++) begin
      stat_flags = 4'(f);
      now_time = 16'(f * 11 + 3);
      ext_pulse();
      chk_stat("R8", 0, 0, 0);
      chk_rec("R8", 0, f * 11 + 3, f);
    end

    // R8 single mode while full: entry 0 overwritten, status held
    wreg(2'd0, 8'h09);
    do_clear(8'h09);
    for (int i = 0; i < DEPTH; i++) ext_pulse();
    wreg(2'd0, 8'h08);
    now_time = 16'h4242; stat_flags = 4'hA;
    ext_pulse();
    chk_stat("R8", 0, 0, 1);
    chk_rec("R8", 0, 16'h4242, 4'hA);

    // R9 clear wins over simultaneous capture
    wreg(2'd0, 8'h0B);
    ext_evt = 1'b1; cyc();
    ext_evt = 1'b0; cyc();
    chk_stat("R9", 0, 1, 0);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule